// File: doc/BRIEF.md
# Per-Thread Stream Destination Mapper

This block sits between the transmit side of a multi-port Ethernet switch and the packet engines of a network coprocessor. Every packet leaves the switch tagged with a 6-bit thread number. The number is built from the ingress port and the priority: port times eight, plus priority. So 64 threads cover eight ports with eight priorities each. For each thread, a programmable table holds a destination code. The code picks one of eleven downstream ports: two packet DMA engines, five ingress engines, one post-processing engine and three egress engines.

The table is reached through a simple memory-mapped register bus. Each 32-bit word holds the codes for four consecutive threads, one code per byte. A byte value outside the legal code range is refused, and the refusal affects only that byte. Other bytes in the same write are still updated.

On the stream side, the destination is looked up on the start-of-packet beat and held until the end-of-packet beat. Valid goes out on the chosen port only. Ready comes back from that same port. Data, packet markers and the thread tag pass through with no register stage.

Top module: `thread_route_top`

## Requirements
- R1: After reset every table byte reads 0, so every thread is steered to output port 0 (global packet DMA).
- R2: Table word N sits at byte address 4N, selected by cfg_addr[5:2]. Its byte j (bits 8j+7:8j) holds the code for thread 4N+j. cfg_rdata shows the addressed word in the same cycle, and reading changes nothing.
- R3: A write with cfg_wr high stores each byte whose value is 0 to 10 into its field, visible from the next cycle.
- R4: A byte value from 11 to 255 leaves its field unchanged. The other bytes of the same write that hold legal values are still stored.
- R5: The index of the output port equals the code: 0 global DMA, 1 local DMA, 2 to 6 ingress engines 0 to 4, 7 post-processing, 8 to 10 egress engines 0 to 2. A start-of-packet beat goes to the port coded for its in_thread.
- R6: While in_valid is high, exactly one bit of out_valid is high. While in_valid is low, out_valid is all zero.
- R7: Once a start-of-packet beat is accepted without end-of-packet, later beats up to and including the end-of-packet beat go to the same port. This holds even if the thread's field is rewritten or in_thread changes in the meantime.
- R8: in_ready equals out_ready of the selected port. The ready inputs of the other ten ports have no effect.
- R9: out_data, out_sop, out_eop and out_thread equal in_data, in_sop, in_eop and in_thread in the same cycle, so a thread routed to a DMA port keeps its number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Table write strobe |
| cfg_addr | input | 6 | Byte address of the table word |
| cfg_wdata | input | 32 | Write data, four code bytes |
| cfg_rdata | output | 32 | Addressed table word |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_thread | input | 6 | Thread tag (port*8 + priority) |
| in_data | input | 32 | Beat payload |
| out_valid | output | 11 | Per-port valid, bit index = destination code |
| out_ready | input | 11 | Per-port ready |
| out_sop | output | 1 | Passed-through start marker |
| out_eop | output | 1 | Passed-through end marker |
| out_thread | output | 6 | Passed-through thread tag |
| out_data | output | 32 | Passed-through payload |

## Verification
The stream outputs and in_ready are combinational, so they are due in the same cycle as the input beat. The bench drives each beat just after a falling edge and samples a short delay later, before the next rising edge. A table write becomes visible from the cycle after the rising edge that takes it, and a read is valid in the cycle its address is driven. The bench's reference table changes only after that edge, so each expected destination comes from the table contents the design holds in that cycle. The held destination of a packet that is in flight is tracked in the bench. It is updated only on accepted beats, so stalled beats and writes made in the middle of a packet are predicted correctly.

// File: rtl/route_pkg.sv
package route_pkg;
    // Destination codes; the output port index equals the code.
    typedef enum logic [3:0] {
        DST_GLOBAL_DMA = 4'd0,
        DST_LOCAL_DMA  = 4'd1,
        DST_INGRESS0   = 4'd2,
        DST_INGRESS1   = 4'd3,
        DST_INGRESS2   = 4'd4,
        DST_INGRESS3   = 4'd5,
        DST_INGRESS4   = 4'd6,
        DST_POSTPROC   = 4'd7,
        DST_EGRESS0    = 4'd8,
        DST_EGRESS1    = 4'd9,
        DST_EGRESS2    = 4'd10
    } dest_e;

    localparam int unsigned DEST_COUNT = 11;
endpackage

// File: rtl/route_table.sv
module route_table #(
    parameter  int THREADS = 64,
    parameter  int LANES   = 4,
    parameter  int FIELD_W = 8,
    parameter  int DEST_N  = route_pkg::DEST_COUNT,
    localparam int WORDS   = THREADS / LANES,
    localparam int WIDX_W  = $clog2(WORDS),
    localparam int AW      = WIDX_W + 2,
    localparam int TW      = $clog2(THREADS),
    localparam int CW      = $clog2(DEST_N),
    localparam int DATA_W  = LANES * FIELD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic [TW-1:0]     look_thread,
    output logic [CW-1:0]     look_code
);
    typedef struct packed {
        logic [THREADS-1:0][CW-1:0] code;
    } tbl_t;

    tbl_t st_d, st_q;
    logic [WIDX_W-1:0] widx;
    wire unused_addr_lsb = ^cfg_addr[1:0];

    assign widx = cfg_addr[AW-1:2];

    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            for (int l = 0; l < LANES; l++) begin
                if (cfg_wdata[l*FIELD_W +: FIELD_W] < FIELD_W'(DEST_N)) begin
                    st_d.code[int'(widx)*LANES + l] = cfg_wdata[l*FIELD_W +: CW];
                end
            end
        end
    end

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            cfg_rdata[l*FIELD_W +: FIELD_W] = FIELD_W'(st_q.code[int'(widx)*LANES + l]);
        end
    end

    assign look_code = st_q.code[look_thread];

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
            assert_illegal_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_wr && cfg_wdata[g*FIELD_W +: FIELD_W] >= FIELD_W'(DEST_N))
                |=> st_q.code[int'($past(widx))*LANES + g] == $past(st_q.code[int'(widx)*LANES + g]));
            assert_legal_stored_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_wr && cfg_wdata[g*FIELD_W +: FIELD_W] < FIELD_W'(DEST_N))
                |=> st_q.code[int'($past(widx))*LANES + g] == $past(cfg_wdata[g*FIELD_W +: CW]));
        end
        for (genvar t = 0; t < THREADS; t++) begin : g_code_chk
            assert_code_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
                int'(st_q.code[t]) < DEST_N);
        end
    endgenerate
endmodule

// File: rtl/route_steer.sv
module route_steer #(
    parameter  int DEST_N = route_pkg::DEST_COUNT,
    localparam int CW     = $clog2(DEST_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    output logic              in_ready,
    input  logic [CW-1:0]     look_code,
    output logic [DEST_N-1:0] out_valid,
    input  logic [DEST_N-1:0] out_ready
);
    typedef struct packed {
        logic          in_pkt;
        logic [CW-1:0] code;
    } steer_t;

    steer_t st_d, st_q;
    logic [CW-1:0] sel;

    // A fresh lookup on every start beat; otherwise the held packet target.
    assign sel       = (st_q.in_pkt && !in_sop) ? st_q.code : look_code;
    assign out_valid = in_valid ? (DEST_N'(1) << sel) : '0;
    assign in_ready  = out_ready[sel];

    always_comb begin
        st_d = st_q;
        if (in_valid && in_ready) begin
            st_d.in_pkt = !in_eop;
            st_d.code   = sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_one_port_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> $countones(out_valid) == 1);
    assert_idle_ports_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> out_valid == '0);
    assert_stall_no_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready) |-> (out_valid & out_ready) == '0);
    assert_packet_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_sop && $past(rst_n) && $past(in_valid && in_ready && !in_eop))
        |-> out_valid == $past(out_valid));
endmodule

// File: rtl/thread_route_top.sv
module thread_route_top #(
    parameter  int THREADS = 64,
    parameter  int LANES   = 4,
    parameter  int FIELD_W = 8,
    parameter  int DEST_N  = route_pkg::DEST_COUNT,
    parameter  int DW      = 32,
    localparam int TW      = $clog2(THREADS),
    localparam int AW      = $clog2(THREADS / LANES) + 2,
    localparam int CW      = $clog2(DEST_N),
    localparam int CFG_W   = LANES * FIELD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [TW-1:0]     in_thread,
    input  logic [DW-1:0]     in_data,
    output logic [DEST_N-1:0] out_valid,
    input  logic [DEST_N-1:0] out_ready,
    output logic              out_sop,
    output logic              out_eop,
    output logic [TW-1:0]     out_thread,
    output logic [DW-1:0]     out_data
);
    logic [CW-1:0] look_code;

    route_table #(
        .THREADS(THREADS), .LANES(LANES), .FIELD_W(FIELD_W), .DEST_N(DEST_N)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .look_thread(in_thread), .look_code(look_code)
    );

    route_steer #(.DEST_N(DEST_N)) u_steer (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_ready(in_ready),
        .look_code(look_code), .out_valid(out_valid), .out_ready(out_ready)
    );

    // Sideband shared by all ports; only the valid bit selects the port.
    assign out_sop    = in_sop;
    assign out_eop    = in_eop;
    assign out_thread = in_thread;
    assign out_data   = in_data;
endmodule

// File: tb/thread_route_top_test.sv
module thread_route_top_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr;
    logic [5:0]  cfg_addr;
    logic [31:0] cfg_wdata, cfg_rdata;
    logic        in_valid, in_ready, in_sop, in_eop;
    logic [5:0]  in_thread, out_thread;
    logic [31:0] in_data, out_data;
    logic [10:0] out_valid, out_ready;
    logic        out_sop, out_eop;

    always #5 clk = ~clk;

    thread_route_top uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .in_valid(in_valid), .in_ready(in_ready), .in_sop(in_sop), .in_eop(in_eop),
        .in_thread(in_thread), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_sop(out_sop),
        .out_eop(out_eop), .out_thread(out_thread), .out_data(out_data)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [3:0] model [64];
    bit b_inpkt = 0;
    int b_dest = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input int n);
        logic [31:0] w;
        for (int j = 0; j < 4; j++) w[j*8 +: 8] = {4'd0, model[n*4+j]};
        return w;
    endfunction

    // One cycle: drive after the falling edge, check before the rising edge.
    task automatic step(input bit v, input bit sop, input bit eop, input logic [5:0] th,
                        input logic [31:0] d, input bit wr, input logic [5:0] a,
                        input logic [31:0] wd, input logic [10:0] rdy, output bit acc);
        int e;
        bit mid;
        @(negedge clk);
        in_valid = v; in_sop = sop; in_eop = eop; in_thread = th; in_data = d;
        cfg_wr = wr; cfg_addr = a; cfg_wdata = wd; out_ready = rdy;
        #2;
        mid = b_inpkt && !sop;
        e = mid ? b_dest : int'(model[th]);
        if (v) begin
            if (mid) chk(out_valid == (11'd1 << e), "R7", "held port", out_valid, 11'd1 << e);
            else     chk(out_valid == (11'd1 << e), "R5", "start port", out_valid, 11'd1 << e);
            chk(in_ready == rdy[e], "R8", "in_ready", in_ready, rdy[e]);
        end else begin
            chk(out_valid == 11'd0, "R6", "idle valid", out_valid, 0);
        end
        chk({out_sop, out_eop, out_thread, out_data} == {sop, eop, th, d}, "R9",
            "sideband", {out_sop, out_eop, out_thread, out_data}, {sop, eop, th, d});
        acc = v && rdy[e];
        @(posedge clk);
        if (acc) begin b_inpkt = !eop; b_dest = e; end
        if (wr) begin
            for (int j = 0; j < 4; j++)
                if (wd[j*8 +: 8] <= 8'd10) model[int'(a[5:2])*4+j] = wd[j*8 +: 4];
        end
    endtask

    task automatic cfg_write(input int n, input logic [31:0] wd);
        bit acc;
        step(0, 0, 0, 6'd0, 32'd0, 1, 6'(n*4), wd, 11'h7FF, acc);
    endtask

    task automatic rd_check(input int n, input string req);
        @(negedge clk);
        cfg_wr = 0; in_valid = 0; cfg_addr = 6'(n*4);
        #2;
        chk(cfg_rdata == exp_word(n), req, $sformatf("word %0d", n), cfg_rdata, exp_word(n));
    endtask

    // Packet with optional rewrite of its own field and tag change mid-flight (R7).
    task automatic send_packet(input logic [5:0] th, input int len, input bit disturb,
                               input bit rand_rdy);
        for (int i = 0; i < len; i++) begin
            bit acc = 0;
            int tries = 0;
            logic [5:0] tag = th;
            bit wr = 0;
            logic [31:0] wd = 32'hFFFF_FFFF;
            if (disturb && i > 0) begin
                tag = 6'($urandom);
                wr = 1;
                wd[int'(th[1:0])*8 +: 8] = 8'($urandom % 11);
            end
            while (!acc) begin
                logic [10:0] rdy = 11'h7FF;
                if (rand_rdy && (tries % 3) != 2) rdy = 11'($urandom);
                step(1, i == 0, i == len-1, tag, $urandom, wr, {th[5:2], 2'b00}, wd, rdy, acc);
                tries++;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit acc;
        void'($urandom(32'h5EED_0A11));
        for (int t = 0; t < 64; t++) model[t] = 4'd0;
        rst_n = 0; cfg_wr = 0; cfg_addr = 0; cfg_wdata = 0;
        in_valid = 0; in_sop = 0; in_eop = 0; in_thread = 0; in_data = 0; out_ready = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R1: cleared table, everything to port 0
        for (int n = 0; n < 16; n++) rd_check(n, "R1");
        step(1, 1, 1, 6'd37, 32'hCAFE_0001, 0, 0, 0, 11'h001, acc);
        chk(out_valid == 11'h001, "R1", "reset route", out_valid, 11'h001);

        // R4/R3: mixed legal and illegal bytes in one write
        cfg_write(0, 32'h0A0B_01FF);
        rd_check(0, "R4");
        cfg_write(15, 32'h0B0C_0DFE);
        rd_check(15, "R4");
        cfg_write(15, 32'h0A09_0800);
        rd_check(15, "R3");
        cfg_write(3, 32'h0706_0504);
        rd_check(3, "R2");
        rd_check(3, "R2");

        // R5: each code routes to its port
        for (int c = 0; c < 11; c++) begin
            cfg_write(2, {24'd0, 8'(c)});
            send_packet(6'd8, 1, 0, 0);
        end

        // R8: stall from selected port, others ready
        cfg_write(1, 32'h0000_0004);
        step(1, 1, 1, 6'd4, 32'h1234_5678, 0, 0, 0, 11'h7EF, acc);
        chk(acc == 0, "R8", "stalled beat", acc, 0);
        step(1, 1, 1, 6'd4, 32'h1234_5678, 0, 0, 0, 11'h010, acc);

        // R7: directed rewrite and tag change mid-packet
        cfg_write(1, 32'h0000_0300);
        send_packet(6'd5, 4, 1, 0);
        rd_check(1, "R7");

        // Random table writes with readback
        for (int k = 0; k < 120; k++) begin
            int n = $urandom % 16;
            logic [31:0] wd;
            for (int j = 0; j < 4; j++)
                wd[j*8 +: 8] = ($urandom % 2) ? 8'($urandom % 11) : 8'($urandom);
            cfg_write(n, wd);
            rd_check(n, "R4");
        end

        // Random packets
        for (int k = 0; k < 150; k++)
            send_packet(6'($urandom), 1 + $urandom % 4, ($urandom % 4) == 0, 1);

        for (int n = 0; n < 16; n++) rd_check(n, "R2");
        step(0, 0, 0, 6'd0, 32'd0, 0, 0, 0, 11'h7FF, acc);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule